// File: doc/BRIEF.md
# Elastic Lane Deskew Buffer

This block sits behind the code-group synchronizers of a multi-lane serial converter link receiver. Each lane delivers two decoded octets per clock, each with a control flag, and the lane writes them into a small circular octet buffer. The earlier octet on the link arrives in the low byte of the input pair. Once a lane's synchronizer reports lock, the lane watches for its first alignment marker. The marker is a control-flagged octet of value 0x7C. The lane records where in the buffer the marker was written.

A shared controller waits until every lane has seen its marker. It then releases all read pointers together. Each read pointer starts on its own lane's marker, so every lane presents the marker in the high (first) byte of its output pair in the same cycle. The skew between lanes is absorbed by how far each read pointer trails its write pointer. If that trail would leave the safe window of the buffer, a sticky max-skew flag is raised instead and the lanes are never released.

While running, a link controller can nudge any lane forward or back by one octet. The lane applies the nudge only when its correction enable is high. It reports the read-to-write offset, and it raises a sticky per-lane error when a nudge would push the pointer past either edge of the window.

Top module: `lane_deskew_array`

## Requirements
- R1: Each cycle a lane stores its input pair with the low byte (bits 7:0) as the earlier octet. Output pairs place the earlier octet in the high byte (bits 15:8) and the next octet in the low byte. Control flags follow their octets, with flag bit 0 belonging to the low byte.
- R2: A lane marks on the first octet that has its control flag set and value 0x7C, seen while that lane's sync input is high. If both octets of a pair qualify, the low byte wins. Markers seen with sync low, or without the control flag, are ignored. `lane_aligned[i]` rises on the clock edge that writes lane i's marker.
- R3: On the edge after the last lane marks, `all_aligned` rises, provided no skew fault is pending. On the following edge every lane outputs its marker in the high byte, with `dout_vld` high.
- R4: `ptr_ofs` is 0 for a lane that is not running. At release, the offset of lane i is 4 − p + 2·(cmax − c_i). Here c_i is the input cycle of lane i's marker, p is 1 if the marker was in the high byte and 0 otherwise, and cmax is the latest c over all lanes.
- R5: If any lane's released offset would exceed DEPTH−2 (14), `max_skew` is set instead of `all_aligned`. `max_skew` is sticky until reset, and it holds the lanes unreleased.
- R6: While running, an advance command skips one octet and a retard command repeats one octet. The offset changes by −1 or +1 respectively on the edge that takes the command. The output reflects the change from the next edge.
- R7: Commands on a lane whose `corr_en` is low, and simultaneous advance and retard, are ignored: the offset and the data stream are unchanged.
- R8: An advance at offset 2, or a retard at offset DEPTH−2, is not applied. Instead it sets the sticky `uncorr_err` bit of that lane.
- R9: A synchronous active-low reset clears the pointers, the marked and aligned state, the flags and the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lane_sync | input | LANES | Per-lane code-group lock; arms marker search |
| rx_octets | input | LANES*16 | Two octets per lane; low byte earlier |
| rx_kflag | input | LANES*2 | Control flag per octet, bit 0 for low byte |
| corr_en | input | LANES | Per-lane enable for running corrections |
| corr_adv | input | LANES | Advance lane by one octet |
| corr_ret | input | LANES | Retard lane by one octet |
| dout | output | LANES*16 | Aligned octet pairs, high byte first |
| dout_k | output | LANES*2 | Control flags of the output octets |
| dout_vld | output | 1 | Output pairs carry released data |
| ptr_ofs | output | LANES*4 | Read-to-write offset per lane |
| lane_aligned | output | LANES | Lane has seen its marker |
| all_aligned | output | 1 | All lanes released together |
| max_skew | output | 1 | Initial skew exceeds buffer window |
| uncorr_err | output | LANES | Correction refused at window edge |

## Verification
The hardest conditions to reach are the two window edges. One is an initial skew that lands the early lane exactly on offset 14. The other is a pointer that has been walked all the way to offset 2 or 14 by repeated commands. The bench reaches the first by placing each lane's marker at a chosen input cycle and byte position from a table, including one row at the limit and rows one step past it. It reaches the second by issuing runs of single-octet commands after a release. Along the way it tracks the expected offset and the octet index each lane should output.

// File: rtl/deskew_pkg.sv
package deskew_pkg;
   localparam logic [7:0] ALIGN_CHAR = 8'h7C;

   typedef struct packed {
      logic       is_k;
      logic [7:0] val;
   } octet_t;
endpackage

// File: rtl/deskew_mark_find.sv
module deskew_mark_find
   import deskew_pkg::*;
(
   input  logic   armed,
   input  octet_t early,
   input  octet_t later,
   output logic   hit,
   output logic   at_later
);
   logic hit_e, hit_l;

   assign hit_e    = armed & early.is_k & (early.val == ALIGN_CHAR);
   assign hit_l    = armed & later.is_k & (later.val == ALIGN_CHAR);
   assign hit      = hit_e | hit_l;
   assign at_later = ~hit_e;
endmodule

// File: rtl/deskew_lane.sv
module deskew_lane
   import deskew_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int SKW   = 5
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       sync_ok,
   input  logic [15:0]                octets,
   input  logic [1:0]                 kflags,
   input  logic                       load,
   input  logic                       running,
   input  logic                       corr_en,
   input  logic                       corr_adv,
   input  logic                       corr_ret,
   output logic                       marked,
   output logic [SKW-1:0]             skew,
   output logic [$clog2(DEPTH)-1:0]   ofs,
   output logic [15:0]                dout,
   output logic [1:0]                 dout_k,
   output logic                       uncorr
);
   localparam int PW      = $clog2(DEPTH);
   localparam int OFS_MIN = 2;
   localparam int OFS_MAX = DEPTH - 2;
   localparam int SK_TOP  = (1 << SKW) - 1;

   octet_t          mem [DEPTH];
   octet_t          early, later;
   logic [PW-1:0]   wp, rd, mark_ptr, ofs_raw, rd_step;
   logic            hit, at_later;
   logic            want_adv, want_ret, at_min, at_max;

   assign early = '{is_k: kflags[0], val: octets[7:0]};
   assign later = '{is_k: kflags[1], val: octets[15:8]};

   deskew_mark_find i_find (
      .armed    (sync_ok & ~marked),
      .early    (early),
      .later    (later),
      .hit      (hit),
      .at_later (at_later)
   );

   assign ofs_raw  = wp - rd;
   assign ofs      = running ? ofs_raw : '0;
   assign want_adv = running & corr_en & corr_adv & ~corr_ret;
   assign want_ret = running & corr_en & corr_ret & ~corr_adv;
   assign at_min   = (ofs_raw == PW'(OFS_MIN));
   assign at_max   = (ofs_raw == PW'(OFS_MAX));

   always_comb begin
      rd_step = PW'(2);
      if (want_adv && !at_min)
         rd_step = PW'(3);
      else if (want_ret && !at_max)
         rd_step = PW'(1);
   end

   always_ff @(posedge clk) begin
      mem[wp]          <= early;
      mem[wp + PW'(1)] <= later;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp       <= '0;
         rd       <= '0;
         mark_ptr <= '0;
         marked   <= 1'b0;
         skew     <= '0;
         dout     <= '0;
         dout_k   <= '0;
         uncorr   <= 1'b0;
      end else begin
         wp <= wp + PW'(2);
         if (hit) begin
            marked   <= 1'b1;
            mark_ptr <= at_later ? wp + PW'(1) : wp;
            skew     <= at_later ? SKW'(1) : SKW'(2);
         end else if (marked && !running) begin
            skew <= (skew >= SKW'(SK_TOP - 1)) ? SKW'(SK_TOP) : skew + SKW'(2);
         end
         if (load)
            rd <= mark_ptr;
         else if (running)
            rd <= rd + rd_step;
         if (running) begin
            dout   <= {mem[rd].val, mem[rd + PW'(1)].val};
            dout_k <= {mem[rd].is_k, mem[rd + PW'(1)].is_k};
         end
         uncorr <= uncorr | (want_adv & at_min) | (want_ret & at_max);
      end
   end
endmodule

// File: rtl/deskew_ctrl.sv
module deskew_ctrl #(
   parameter int LANES = 2,
   parameter int SKW   = 5,
   parameter int LIM   = 12
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [LANES-1:0]      lane_marked,
   input  logic [LANES*SKW-1:0]  lane_skew,
   output logic                  load,
   output logic                  aligned,
   output logic                  max_skew,
   output logic                  vld
);
   logic over;

   always_comb begin
      over = 1'b0;
      for (int i = 0; i < LANES; i++)
         if (lane_skew[i*SKW +: SKW] > SKW'(LIM))
            over = 1'b1;
   end

   assign load = ~aligned & ~max_skew & (&lane_marked) & ~over;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         aligned  <= 1'b0;
         max_skew <= 1'b0;
         vld      <= 1'b0;
      end else begin
         aligned  <= aligned | load;
         max_skew <= max_skew | (~aligned & over);
         vld      <= aligned;
      end
   end
endmodule

// File: rtl/lane_deskew_array.sv
module lane_deskew_array #(
   parameter int LANES = 2,
   parameter int DEPTH = 16
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [LANES-1:0]                 lane_sync,
   input  logic [LANES*16-1:0]              rx_octets,
   input  logic [LANES*2-1:0]               rx_kflag,
   input  logic [LANES-1:0]                 corr_en,
   input  logic [LANES-1:0]                 corr_adv,
   input  logic [LANES-1:0]                 corr_ret,
   output logic [LANES*16-1:0]              dout,
   output logic [LANES*2-1:0]               dout_k,
   output logic                             dout_vld,
   output logic [LANES*$clog2(DEPTH)-1:0]   ptr_ofs,
   output logic [LANES-1:0]                 lane_aligned,
   output logic                             all_aligned,
   output logic                             max_skew,
   output logic [LANES-1:0]                 uncorr_err
);
   localparam int PW  = $clog2(DEPTH);
   localparam int SKW = PW + 1;
   localparam int LIM = DEPTH - 4;

   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 8) begin : g_bad_depth
      $error("lane_deskew_array: DEPTH must be a power of two of at least 8");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("lane_deskew_array: LANES must be at least 1");
   end

   logic [LANES-1:0]     marked;
   logic [LANES*SKW-1:0] skew;
   logic                 load;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      deskew_lane #(.DEPTH(DEPTH), .SKW(SKW)) i_lane (
         .clk      (clk),
         .rst_n    (rst_n),
         .sync_ok  (lane_sync[g]),
         .octets   (rx_octets[g*16 +: 16]),
         .kflags   (rx_kflag[g*2 +: 2]),
         .load     (load),
         .running  (all_aligned),
         .corr_en  (corr_en[g]),
         .corr_adv (corr_adv[g]),
         .corr_ret (corr_ret[g]),
         .marked   (marked[g]),
         .skew     (skew[g*SKW +: SKW]),
         .ofs      (ptr_ofs[g*PW +: PW]),
         .dout     (dout[g*16 +: 16]),
         .dout_k   (dout_k[g*2 +: 2]),
         .uncorr   (uncorr_err[g])
      );
   end

   deskew_ctrl #(.LANES(LANES), .SKW(SKW), .LIM(LIM)) i_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .lane_marked (marked),
      .lane_skew   (skew),
      .load        (load),
      .aligned     (all_aligned),
      .max_skew    (max_skew),
      .vld         (dout_vld)
   );

   assign lane_aligned = marked;
endmodule

// File: rtl/deskew_chk.sv
module deskew_chk #(
   parameter int LANES = 2,
   parameter int DEPTH = 16
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic [LANES-1:0]                lane_aligned,
   input logic                            all_aligned,
   input logic                            max_skew,
   input logic                            dout_vld,
   input logic [LANES-1:0]                corr_en,
   input logic [LANES-1:0]                uncorr_err,
   input logic [LANES*$clog2(DEPTH)-1:0]  ptr_ofs
);
   localparam int PW = $clog2(DEPTH);

   a_r3_release_needs_all: assert property (@(posedge clk) disable iff (!rst_n)
      all_aligned |-> (&lane_aligned));

   a_r3_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(all_aligned) |=> dout_vld);

   a_r5_skew_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      !(max_skew && all_aligned));

   a_r5_skew_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      max_skew |=> max_skew);

   for (genvar g = 0; g < LANES; g++) begin : g_chk
      a_r2_mark_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         lane_aligned[g] |=> lane_aligned[g]);

      a_r8_ofs_window: assert property (@(posedge clk) disable iff (!rst_n)
         all_aligned |-> (ptr_ofs[g*PW +: PW] >= PW'(2) && ptr_ofs[g*PW +: PW] <= PW'(DEPTH - 2)));

      a_r8_uncorr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         uncorr_err[g] |=> uncorr_err[g]);

      a_r7_disabled_holds: assert property (@(posedge clk) disable iff (!rst_n)
         (all_aligned && !corr_en[g]) |=> (ptr_ofs[g*PW +: PW] == $past(ptr_ofs[g*PW +: PW])));
   end
endmodule

bind lane_deskew_array deskew_chk #(.LANES(LANES), .DEPTH(DEPTH)) i_deskew_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .lane_aligned (lane_aligned),
   .all_aligned  (all_aligned),
   .max_skew     (max_skew),
   .dout_vld     (dout_vld),
   .corr_en      (corr_en),
   .uncorr_err   (uncorr_err),
   .ptr_ofs      (ptr_ofs)
);

// File: tb/test_lane_deskew_array.sv
`timescale 1ns/1ps
module test_lane_deskew_array;
   localparam int L = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [L-1:0]  lane_sync = '0;
   logic [L*16-1:0] rx_octets = '0;
   logic [L*2-1:0]  rx_kflag = '0;
   logic [L-1:0]  corr_en = '0, corr_adv = '0, corr_ret = '0;
   logic [L*16-1:0] dout;
   logic [L*2-1:0]  dout_k;
   logic          dout_vld;
   logic [L*4-1:0] ptr_ofs;
   logic [L-1:0]  lane_aligned;
   logic          all_aligned, max_skew;
   logic [L-1:0]  uncorr_err;

   always #2.5 clk = ~clk;

   lane_deskew_array #(.LANES(L), .DEPTH(16)) i_lane_deskew_array (
      .clk(clk), .rst_n(rst_n), .lane_sync(lane_sync), .rx_octets(rx_octets),
      .rx_kflag(rx_kflag), .corr_en(corr_en), .corr_adv(corr_adv), .corr_ret(corr_ret),
      .dout(dout), .dout_k(dout_k), .dout_vld(dout_vld), .ptr_ofs(ptr_ofs),
      .lane_aligned(lane_aligned), .all_aligned(all_aligned), .max_skew(max_skew),
      .uncorr_err(uncorr_err)
   );

   // rows: marker cycle lane0, byte pos lane0, cycle lane1, pos lane1, ofs0, ofs1, max_skew
   localparam int TBL [7][7] = '{
      '{2, 0, 2, 0,  4,  4, 0},
      '{2, 1, 2, 0,  3,  4, 0},
      '{1, 0, 4, 1, 10,  3, 0},
      '{3, 1, 0, 0,  3, 10, 0},
      '{0, 0, 5, 0, 14,  4, 0},
      '{0, 1, 6, 0,  0,  0, 1},
      '{0, 0, 7, 1,  0,  0, 1}
   };

   int n_tests = 0, n_fail = 0;
   int cyc;
   int mc [L];
   int mp [L];
   bit mk [L];
   bit ms [L];
   int nxt [L];
   int eofs [L];
   bit euc [L];

   function automatic logic [8:0] oct(int ln, int idx);
      if (idx == 2 * mc[ln] + mp[ln]) return {mk[ln], 8'h7C};
      return {1'b0, 8'(ln * 64 + idx)};
   endfunction

   task automatic chk(bit ok, string req, string what, int act, int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic drive_pair();
      @(negedge clk);
      for (int ln = 0; ln < L; ln++) begin
         logic [8:0] lo, hi;
         lo = oct(ln, 2 * cyc);
         hi = oct(ln, 2 * cyc + 1);
         rx_octets[ln*16 +: 16] = {hi[7:0], lo[7:0]};
         rx_kflag[ln*2 +: 2]    = {hi[8], lo[8]};
         lane_sync[ln]          = ms[ln];
      end
      cyc++;
      @(posedge clk);
      #1;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      rx_octets = '0; rx_kflag = '0; lane_sync = '0;
      corr_en = '0; corr_adv = '0; corr_ret = '0;
      @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      cyc = 0;
   endtask

   task automatic check_idle(string req);
      chk(dout == '0 && dout_k == '0, req, "dout idle", int'(dout), 0);
      chk(ptr_ofs == '0, req, "ptr_ofs idle", int'(ptr_ofs), 0);
      chk({dout_vld, all_aligned, max_skew} == 3'b0, req, "flags idle",
          int'({dout_vld, all_aligned, max_skew}), 0);
      chk(lane_aligned == '0 && uncorr_err == '0, req, "lane flags idle",
          int'({lane_aligned, uncorr_err}), 0);
   endtask

   task automatic run_row(int r);
      int cmax;
      mc[0] = TBL[r][0]; mp[0] = TBL[r][1];
      mc[1] = TBL[r][2]; mp[1] = TBL[r][3];
      mk = '{1, 1}; ms = '{1, 1};
      cmax = (mc[0] > mc[1]) ? mc[0] : mc[1];
      do_reset();
      for (int k = 0; k <= cmax + 2; k++) begin
         drive_pair();
         if (k == cmax && TBL[r][6] == 0) begin
            chk(lane_aligned == 2'b11, "R2", "lane_aligned at last marker", int'(lane_aligned), 3);
            chk(all_aligned == 1'b0, "R3", "all_aligned one cycle later", int'(all_aligned), 0);
         end
      end
      if (TBL[r][6] != 0) begin
         chk(max_skew == 1'b1, "R5", "max_skew", int'(max_skew), 1);
         chk(all_aligned == 1'b0 && dout_vld == 1'b0, "R5", "held unreleased",
             int'({all_aligned, dout_vld}), 0);
      end else begin
         chk(all_aligned && dout_vld && !max_skew, "R3", "release flags",
             int'({all_aligned, dout_vld, max_skew}), 6);
         for (int ln = 0; ln < L; ln++) begin
            logic [8:0] nx;
            nx = oct(ln, 2 * mc[ln] + mp[ln] + 1);
            chk(dout[ln*16 +: 16] == {8'h7C, nx[7:0]} && dout_k[ln*2 +: 2] == {1'b1, nx[8]},
                "R1", "marker in high byte", int'(dout[ln*16 +: 16]), int'({8'h7C, nx[7:0]}));
            chk(ptr_ofs[ln*4 +: 4] == 4'(TBL[r][4 + ln]), "R4", "release offset",
                int'(ptr_ofs[ln*4 +: 4]), TBL[r][4 + ln]);
            nxt[ln]  = 2 * mc[ln] + mp[ln] + 2;
            eofs[ln] = TBL[r][4 + ln];
            euc[ln]  = 1'b0;
         end
      end
   endtask

   task automatic cstep(bit a0, bit r0, bit a1, bit r1, bit e0, bit e1, string req);
      bit a [L], rt [L], e [L];
      int d [L];
      a = '{a0, a1}; rt = '{r0, r1}; e = '{e0, e1};
      for (int ln = 0; ln < L; ln++) begin
         d[ln] = 0;
         if (e[ln] && (a[ln] ^ rt[ln])) begin
            if (a[ln]) begin
               if (eofs[ln] == 2) euc[ln] = 1'b1;
               else begin d[ln] = 1; eofs[ln]--; end
            end else begin
               if (eofs[ln] == 14) euc[ln] = 1'b1;
               else begin d[ln] = -1; eofs[ln]++; end
            end
         end
      end
      corr_adv = {a1, a0}; corr_ret = {r1, r0}; corr_en = {e1, e0};
      drive_pair();
      corr_adv = '0; corr_ret = '0;
      for (int ln = 0; ln < L; ln++) begin
         logic [8:0] h, lo;
         h  = oct(ln, nxt[ln]);
         lo = oct(ln, nxt[ln] + 1);
         chk(dout[ln*16 +: 16] == {h[7:0], lo[7:0]}, req, "data stream",
             int'(dout[ln*16 +: 16]), int'({h[7:0], lo[7:0]}));
         chk(ptr_ofs[ln*4 +: 4] == 4'(eofs[ln]), req, "offset", int'(ptr_ofs[ln*4 +: 4]), eofs[ln]);
         chk(uncorr_err[ln] == euc[ln], req, "uncorr_err", int'(uncorr_err[ln]), int'(euc[ln]));
         nxt[ln] = nxt[ln] + 2 + d[ln];
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      mc = '{0, 0}; mp = '{0, 0}; mk = '{1, 1}; ms = '{0, 0};
      do_reset();
      #1;
      check_idle("R9");

      for (int r = 0; r < 7; r++) run_row(r);

      // R2: marker ignored while sync is low, and when the control flag is clear
      mc = '{1, 1}; mp = '{0, 0}; mk = '{1, 1}; ms = '{0, 1};
      do_reset();
      repeat (5) drive_pair();
      chk(lane_aligned == 2'b10, "R2", "sync low ignores marker", int'(lane_aligned), 2);
      chk(all_aligned == 1'b0 && ptr_ofs == '0, "R4", "no release, zero offset",
          int'({all_aligned, ptr_ofs}), 0);
      mk = '{0, 1}; ms = '{1, 1};
      do_reset();
      repeat (5) drive_pair();
      chk(lane_aligned == 2'b10, "R2", "unflagged 0x7C ignored", int'(lane_aligned), 2);

      // R6, R7, R8: running corrections from a clean release
      run_row(0);
      cstep(1, 0, 0, 0, 1, 1, "R6");
      cstep(1, 0, 0, 0, 1, 1, "R6");
      cstep(1, 0, 0, 0, 1, 1, "R8");
      cstep(0, 0, 1, 0, 1, 0, "R7");
      cstep(0, 0, 1, 1, 1, 1, "R7");
      for (int i = 0; i < 10; i++) cstep(0, 0, 0, 1, 1, 1, "R6");
      cstep(0, 0, 0, 1, 1, 1, "R8");
      cstep(0, 0, 0, 0, 1, 1, "R6");

      // R9: reset mid-run clears everything
      do_reset();
      #1;
      check_idle("R9");

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule